// File: doc/BRIEF.md
# Single-Cell Charge Sequencing Controller

This block sequences one charge cycle of a single nickel-metal-hydride cell. It sees only digital flags from external comparators (supply good, suspend request, cell below 1.0 V, cell above the no-current and with-current over-voltage limits, three temperature limits, impedance failure and end-of-charge detection), together with a time-base tick and a programmed fast-charge timeout in minutes. It steps through waiting for a cell, precharge, fast charge, top-off, maintenance and fault. Two override states take priority over all of these: power-on reset and suspend.

Its outputs are a 3-bit state code, the requested charge mode, and a charge-enable flag. The charge-enable flag already includes the duty pattern of the mode. An external current regulator turns the charge transistor on only while this flag is high. Because the flag shows whether current is flowing at that moment, the controller uses it to select which over-voltage flag counts as a fault.

Top module: `nimh_charge_seq`

## Requirements
- R1: While the supply-good input is low, the block enters the reset state (code 0) with charge disabled, and its minute and duty counters are cleared. It also enters this state when rst_n is sampled low. With supply good, the reset state moves to waiting-for-cell (code 1) one cycle later.
- R2: A suspend request with supply good enters suspend (code 7) with charge disabled, from any state. When the request is released, the next state is waiting-for-cell.
- R3: Waiting-for-cell moves to precharge (code 2) only when the no-current over-voltage flag, the too-cold flag and the too-warm flag are all low. Otherwise it stays.
- R4: Precharge uses quarter mode (mode 2). When the below-1.0 V flag goes low, it moves to fast charge (code 3). It faults (code 6) when the too-hot flag is set, or when PRECHG_MIN minutes pass in precharge.
- R5: Fast charge uses full mode (mode 1) with charge always enabled. It moves to top-off (code 4) when the end-of-charge flag is set, or after the programmed number of minutes.
- R6: Top-off uses quarter mode. It moves to maintenance (code 5, mode 3) when the too-hot flag is set, or after half the programmed minutes (rounded down), counted from top-off entry. The too-hot flag during fast charge also moves to maintenance.
- R7: In precharge, fast charge and top-off, a fault is raised by the with-current over-voltage flag while charge is enabled. While charge is disabled, the no-current flag raises it instead. During fast charge, an impedance failure also raises a fault.
- R8: Fault (mode 0, charge disabled) and maintenance stay where they are until the with-current over-voltage flag is set, which marks cell removal. They then move to waiting-for-cell.
- R9: In quarter mode, charge is enabled on 1 tick phase in 4. In maintenance it is enabled on 1 phase in 64. The phase counter restarts at zero on every state change.
- R10: One minute is TICKS_PER_MIN time-base ticks. The minute count restarts on every state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| supply_ok | input | 1 | Supply above lockout level |
| suspend_req | input | 1 | Request to halt charging |
| vcell_low | input | 1 | Cell below 1.0 V |
| ov_open | input | 1 | Cell above the no-current over-voltage limit |
| ov_charge | input | 1 | Cell above the with-current over-voltage limit |
| too_cold | input | 1 | Below the start temperature window |
| too_warm | input | 1 | Above the start temperature window |
| too_hot | input | 1 | Above the stop temperature |
| imp_fail | input | 1 | Cell-test impedance failure |
| term_done | input | 1 | End-of-charge detected |
| tick | input | 1 | Time-base tick, one cycle wide |
| fast_tmo_min | input | TMO_W | Fast-charge timeout in minutes |
| state_code | output | 3 | Current state code |
| chg_mode | output | 2 | 0 off, 1 full, 2 quarter, 3 maintenance |
| chg_en | output | 1 | Charge current enable, duty pattern applied |

## Verification
The hardest case to reach from the ports is the over-voltage limit selection. The same no-current flag must be ignored while current flows and must cause a fault as soon as current stops, even though the state does not change. The stimulus holds the tick low on entry to precharge, so charge enable stays high while the no-current flag is raised. It then sends exactly one tick, which moves the duty phase into its off part, and checks for the fault on the following edge. The timeout checks place samples a few cycles before and after each computed expiry. After a supply dropout, the run re-enters precharge to show that the minute count started again from zero.

// File: rtl/nimh_seq_pkg.sv
// Package: shared state and mode encodings for the charge sequencer.
// Assumes: codes are visible at the ports and must stay fixed.
package nimh_seq_pkg;

    typedef enum logic [2:0] {
        ST_RESET   = 3'd0,
        ST_WAIT    = 3'd1,
        ST_PRECHG  = 3'd2,
        ST_FAST    = 3'd3,
        ST_TOPOFF  = 3'd4,
        ST_MAINT   = 3'd5,
        ST_FAULT   = 3'd6,
        ST_SUSPEND = 3'd7
    } chg_state_t;

    typedef enum logic [1:0] {
        MD_OFF   = 2'd0,
        MD_FULL  = 2'd1,
        MD_QTR   = 2'd2,
        MD_MAINT = 2'd3
    } chg_mode_t;

endpackage

// File: rtl/chg_min_timer.sv
// Module: counts elapsed minutes in the current phase.
// Divides the tick input by TICKS_PER_MIN to form minutes and saturates the
// minute count. Assumes clr is high on every phase change.
module chg_min_timer #(
    parameter int TICKS_PER_MIN = 60,
    parameter int MIN_W         = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    output logic [MIN_W-1:0] elapsed
);
    localparam int PW = (TICKS_PER_MIN > 1) ? $clog2(TICKS_PER_MIN) : 1;
    localparam logic [PW-1:0]    PRESC_LAST = PW'(TICKS_PER_MIN - 1);
    localparam logic [MIN_W-1:0] MIN_SAT    = '1;

    logic [PW-1:0] presc_q;
    logic          min_pulse;

    // Marks the tick that completes a minute.
    always_comb min_pulse = tick && (presc_q == PRESC_LAST);

    // Tick prescaler, restarted with the phase.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)    presc_q <= '0;
        else if (min_pulse)   presc_q <= '0;
        else if (tick)        presc_q <= presc_q + 1'b1;
    end

    // Saturating minute count for the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)                      elapsed <= '0;
        else if (min_pulse && elapsed != MIN_SAT) elapsed <= elapsed + 1'b1;
    end

    // R10
    min_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> elapsed >= $past(elapsed));

    // R10
    min_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !tick) |=> $stable(elapsed));

endmodule

// File: rtl/chg_duty_gen.sv
// Module: applies the duty pattern of the charge mode to the enable flag.
// A tick-driven phase counter restarts on clr. Quarter mode enables one
// phase in 2**QTR_SH, maintenance one in 2**MNT_SH. Assumes QTR_SH <= MNT_SH.
module chg_duty_gen
    import nimh_seq_pkg::*;
#(
    parameter int QTR_SH = 2,
    parameter int MNT_SH = 6
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clr,
    input  logic      tick,
    input  chg_mode_t mode,
    output logic      chg_en
);
    logic [MNT_SH-1:0] phase_q;

    // Free-running duty phase, advanced by the time base.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) phase_q <= '0;
        else if (tick)     phase_q <= phase_q + 1'b1;
    end

    // Enable decode per mode.
    always_comb begin
        unique case (mode)
            MD_FULL:  chg_en = 1'b1;
            MD_QTR:   chg_en = (phase_q[QTR_SH-1:0] == '0);
            MD_MAINT: chg_en = (phase_q == '0);
            default:  chg_en = 1'b0;
        endcase
    end

    // R9
    duty_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_OFF) |-> !chg_en);

    // R9
    duty_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MD_FULL && chg_en && tick && !clr && $stable(mode)) |=> !chg_en);

endmodule

// File: rtl/nimh_charge_seq.sv
// Module: top-level charge sequencer for one cell.
// Holds the phase state machine, picks the over-voltage limit from the live
// charge enable, and compares the phase minute count against the timeouts.
// Assumes all flags are synchronous to clk and tick is one cycle wide.
module nimh_charge_seq
    import nimh_seq_pkg::*;
#(
    parameter int TICKS_PER_MIN = 60,
    parameter int TMO_W         = 9,
    parameter int PRECHG_MIN    = 30,
    parameter int QTR_SH        = 2,
    parameter int MNT_SH        = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             supply_ok,
    input  logic             suspend_req,
    input  logic             vcell_low,
    input  logic             ov_open,
    input  logic             ov_charge,
    input  logic             too_cold,
    input  logic             too_warm,
    input  logic             too_hot,
    input  logic             imp_fail,
    input  logic             term_done,
    input  logic             tick,
    input  logic [TMO_W-1:0] fast_tmo_min,
    output logic [2:0]       state_code,
    output logic [1:0]       chg_mode,
    output logic             chg_en
);
    localparam logic [TMO_W-1:0] PRECHG_LIM = TMO_W'(PRECHG_MIN);

    chg_state_t       state_q, state_d;
    chg_mode_t        mode;
    logic             phase_clr;
    logic [TMO_W-1:0] elapsed;
    logic             ov_hit;
    logic             pre_exp, fast_exp, top_exp;

    chg_min_timer #(
        .TICKS_PER_MIN (TICKS_PER_MIN),
        .MIN_W         (TMO_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (phase_clr),
        .tick    (tick),
        .elapsed (elapsed)
    );

    chg_duty_gen #(
        .QTR_SH (QTR_SH),
        .MNT_SH (MNT_SH)
    ) u_duty (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (phase_clr),
        .tick   (tick),
        .mode   (mode),
        .chg_en (chg_en)
    );

    // Over-voltage limit follows whether current flows right now.
    always_comb ov_hit = chg_en ? ov_charge : ov_open;

    // Phase timeout compares.
    always_comb begin
        pre_exp  = (elapsed >= PRECHG_LIM);
        fast_exp = (elapsed >= fast_tmo_min);
        top_exp  = (elapsed >= (fast_tmo_min >> 1));
    end

    // Next-state selection, overrides first.
    always_comb begin
        state_d = state_q;
        if (!supply_ok) begin
            state_d = ST_RESET;
        end else if (suspend_req) begin
            state_d = ST_SUSPEND;
        end else begin
            unique case (state_q)
                ST_RESET, ST_SUSPEND: state_d = ST_WAIT;
                ST_WAIT:
                    if (!ov_open && !too_cold && !too_warm) state_d = ST_PRECHG;
                ST_PRECHG:
                    if (ov_hit || too_hot || pre_exp) state_d = ST_FAULT;
                    else if (!vcell_low)              state_d = ST_FAST;
                ST_FAST:
                    if (ov_hit || imp_fail)           state_d = ST_FAULT;
                    else if (too_hot)                 state_d = ST_MAINT;
                    else if (term_done || fast_exp)   state_d = ST_TOPOFF;
                ST_TOPOFF:
                    if (ov_hit)                       state_d = ST_FAULT;
                    else if (too_hot || top_exp)      state_d = ST_MAINT;
                ST_MAINT, ST_FAULT:
                    if (ov_charge)                    state_d = ST_WAIT;
                default: state_d = ST_RESET;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RESET;
        else        state_q <= state_d;
    end

    // Counters restart on every change and stay cleared in the override states.
    always_comb phase_clr = (state_d != state_q) || (state_q == ST_RESET)
                            || (state_q == ST_SUSPEND);

    // Charge mode per state.
    always_comb begin
        unique case (state_q)
            ST_FAST:             mode = MD_FULL;
            ST_PRECHG, ST_TOPOFF: mode = MD_QTR;
            ST_MAINT:            mode = MD_MAINT;
            default:             mode = MD_OFF;
        endcase
    end

    always_comb begin
        state_code = state_q;
        chg_mode   = mode;
    end

    // R1
    supply_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (state_q == ST_RESET && !chg_en));

    // R2
    suspend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_ok && suspend_req) |=> (state_q == ST_SUSPEND && !chg_en));

    // R3
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && supply_ok && !suspend_req
         && (ov_open || too_cold || too_warm)) |=> state_q == ST_WAIT);

    // R8
    fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FAULT && supply_ok && !suspend_req && !ov_charge)
        |=> state_q == ST_FAULT);

    // R7
    ov_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PRECHG && supply_ok && !suspend_req && !chg_en && ov_open)
        |=> state_q == ST_FAULT);

    // R5
    fast_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FAST) |-> chg_en);

endmodule

// File: tb/nimh_charge_seq_tb.sv
// Scoreboard bench: the driver queues expected outputs, the monitor compares at negedge.
module nimh_charge_seq_tb;
    import nimh_seq_pkg::*;

    localparam int TMO_W = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b0, suspend_req = 1'b0, vcell_low = 1'b1;
    logic ov_open = 1'b1, ov_charge = 1'b0;
    logic too_cold = 1'b0, too_warm = 1'b0, too_hot = 1'b0;
    logic imp_fail = 1'b0, term_done = 1'b0, tick = 1'b0;
    logic [TMO_W-1:0] fast_tmo_min = 9'd10;
    logic [2:0] state_code;
    logic [1:0] chg_mode;
    logic       chg_en;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [2:0] st;
        logic [1:0] md;
        bit         en_chk;
        logic       en;
        string      tag;
    } exp_t;

    exp_t exp_q[$];

    always #10 clk = ~clk;

    nimh_charge_seq #(
        .TICKS_PER_MIN (4),
        .TMO_W         (TMO_W),
        .PRECHG_MIN    (30)
    ) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .supply_ok    (supply_ok),
        .suspend_req  (suspend_req),
        .vcell_low    (vcell_low),
        .ov_open      (ov_open),
        .ov_charge    (ov_charge),
        .too_cold     (too_cold),
        .too_warm     (too_warm),
        .too_hot      (too_hot),
        .imp_fail     (imp_fail),
        .term_done    (term_done),
        .tick         (tick),
        .fast_tmo_min (fast_tmo_min),
        .state_code   (state_code),
        .chg_mode     (chg_mode),
        .chg_en       (chg_en)
    );

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic expect_st(input chg_state_t st, input chg_mode_t md,
                             input bit en_chk, input logic en, input string tag);
        exp_t e;
        e.st = st; e.md = md; e.en_chk = en_chk; e.en = en; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic check_val(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: compares queued expectations against the outputs at negedge.
    initial begin
        forever begin
            @(negedge clk);
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (state_code !== e.st || chg_mode !== e.md
                    || (e.en_chk && chg_en !== e.en)) begin
                    errors++;
                    $display("FAIL %s actual st=%0d md=%0d en=%0b expected st=%0d md=%0d en=%0b",
                             e.tag, state_code, chg_mode, chg_en, e.st, e.md, e.en);
                end
            end
        end
    end

    task automatic remove_and_insert();
        ov_charge = 1'b1;
        wait_cyc(1);
        expect_st(ST_WAIT, MD_OFF, 1, 1'b0, "R8 removal to wait");
        ov_charge = 1'b0;
        wait_cyc(1);
        expect_st(ST_PRECHG, MD_QTR, 0, 1'b0, "R3 insert to precharge");
    endtask

    // Driver.
    initial begin
        int cnt;
        wait_cyc(3);
        expect_st(ST_RESET, MD_OFF, 1, 1'b0, "R1 reset state");
        rst_n = 1'b1; supply_ok = 1'b1;
        wait_cyc(1);
        expect_st(ST_WAIT, MD_OFF, 1, 1'b0, "R1 leave reset");
        wait_cyc(3);
        expect_st(ST_WAIT, MD_OFF, 1, 1'b0, "R3 no cell holds");
        ov_open = 1'b0; too_cold = 1'b1;
        wait_cyc(3);
        expect_st(ST_WAIT, MD_OFF, 1, 1'b0, "R3 cold holds");
        too_cold = 1'b0; too_warm = 1'b1;
        wait_cyc(3);
        expect_st(ST_WAIT, MD_OFF, 1, 1'b0, "R3 warm holds");
        too_warm = 1'b0;
        wait_cyc(1);
        expect_st(ST_PRECHG, MD_QTR, 1, 1'b1, "R4 enter precharge");

        // Limit selection: open limit ignored while current is on.
        ov_open = 1'b1;
        wait_cyc(3);
        expect_st(ST_PRECHG, MD_QTR, 1, 1'b1, "R7 open limit ignored while on");
        tick = 1'b1;
        wait_cyc(1);
        tick = 1'b0;
        expect_st(ST_PRECHG, MD_QTR, 1, 1'b0, "R9 quarter off phase");
        wait_cyc(1);
        expect_st(ST_FAULT, MD_OFF, 1, 1'b0, "R7 open limit while off");
        wait_cyc(4);
        expect_st(ST_FAULT, MD_OFF, 1, 1'b0, "R8 fault held");
        ov_open = 1'b0;
        remove_and_insert();

        // Precharge timeout.
        tick = 1'b1;
        wait_cyc(110);
        expect_st(ST_PRECHG, MD_QTR, 0, 1'b0, "R4 R10 before precharge timeout");
        wait_cyc(20);
        expect_st(ST_FAULT, MD_OFF, 1, 1'b0, "R4 R10 precharge timeout");
        remove_and_insert();

        // Quarter duty: 2 enables in 8 phases from entry.
        cnt = 0;
        for (int i = 0; i < 8; i++) begin
            cnt += int'(chg_en);
            wait_cyc(1);
        end
        check_val(cnt, 2, "R9 quarter duty count");
        too_hot = 1'b1;
        wait_cyc(1);
        expect_st(ST_FAULT, MD_OFF, 1, 1'b0, "R4 hot in precharge");
        too_hot = 1'b0;
        remove_and_insert();

        // Fast charge, end-of-charge, top-off half timeout.
        vcell_low = 1'b0;
        wait_cyc(1);
        expect_st(ST_FAST, MD_FULL, 1, 1'b1, "R4 R5 enter fast");
        term_done = 1'b1;
        wait_cyc(1);
        term_done = 1'b0;
        expect_st(ST_TOPOFF, MD_QTR, 0, 1'b0, "R5 done to topoff");
        wait_cyc(14);
        expect_st(ST_TOPOFF, MD_QTR, 0, 1'b0, "R6 before half timeout");
        wait_cyc(10);
        expect_st(ST_MAINT, MD_MAINT, 0, 1'b0, "R6 half timeout");
        cnt = 0;
        for (int i = 0; i < 64; i++) begin
            cnt += int'(chg_en);
            wait_cyc(1);
        end
        check_val(cnt, 1, "R9 maintenance duty count");
        ov_open = 1'b1;
        wait_cyc(3);
        expect_st(ST_MAINT, MD_MAINT, 0, 1'b0, "R8 maintenance held");
        ov_open = 1'b0;
        remove_and_insert();
        wait_cyc(1);
        expect_st(ST_FAST, MD_FULL, 1, 1'b1, "R5 fast again");

        // Fast timeout then hot top-off.
        wait_cyc(34);
        expect_st(ST_FAST, MD_FULL, 1, 1'b1, "R5 before fast timeout");
        wait_cyc(10);
        expect_st(ST_TOPOFF, MD_QTR, 0, 1'b0, "R5 fast timeout");
        too_hot = 1'b1;
        wait_cyc(1);
        too_hot = 1'b0;
        expect_st(ST_MAINT, MD_MAINT, 0, 1'b0, "R6 hot in topoff");
        remove_and_insert();
        wait_cyc(1);
        too_hot = 1'b1;
        wait_cyc(1);
        too_hot = 1'b0;
        expect_st(ST_MAINT, MD_MAINT, 0, 1'b0, "R6 hot in fast");
        remove_and_insert();
        wait_cyc(1);
        imp_fail = 1'b1;
        wait_cyc(1);
        imp_fail = 1'b0;
        expect_st(ST_FAULT, MD_OFF, 1, 1'b0, "R7 impedance fault");
        remove_and_insert();
        wait_cyc(1);
        ov_charge = 1'b1;
        wait_cyc(1);
        expect_st(ST_FAULT, MD_OFF, 1, 1'b0, "R7 charge limit while on");
        wait_cyc(1);
        ov_charge = 1'b0;
        expect_st(ST_WAIT, MD_OFF, 1, 1'b0, "R8 leave fault");
        wait_cyc(2);
        expect_st(ST_FAST, MD_FULL, 1, 1'b1, "R5 fast before suspend");

        // Suspend and supply loss.
        suspend_req = 1'b1;
        wait_cyc(1);
        expect_st(ST_SUSPEND, MD_OFF, 1, 1'b0, "R2 suspend entry");
        wait_cyc(3);
        expect_st(ST_SUSPEND, MD_OFF, 1, 1'b0, "R2 suspend held");
        suspend_req = 1'b0;
        wait_cyc(1);
        expect_st(ST_WAIT, MD_OFF, 1, 1'b0, "R2 release to wait");
        wait_cyc(2);
        supply_ok = 1'b0;
        wait_cyc(1);
        expect_st(ST_RESET, MD_OFF, 1, 1'b0, "R1 supply loss");
        supply_ok = 1'b1;
        vcell_low = 1'b1;
        wait_cyc(2);
        expect_st(ST_PRECHG, MD_QTR, 0, 1'b0, "R3 precharge before dropout");
        wait_cyc(100);
        supply_ok = 1'b0;
        wait_cyc(1);
        supply_ok = 1'b1;
        wait_cyc(2);
        wait_cyc(100);
        expect_st(ST_PRECHG, MD_QTR, 0, 1'b0, "R1 timer cleared by dropout");

        wait_cyc(3);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule